// File: doc/BRIEF.md
# Downstream Secondary Bus Reset Sequencer

This block supervises one downstream port of a PCI Express switch while software holds that port's secondary bus in reset. When the reset bit in the port's bridge control register goes from 0 to 1, the block runs a fixed sequence. First, if the link was up at that moment, it asks the physical layer to send training sets that carry the hot-reset indication. Next it tells the TLP queue to discard everything it holds from this port. Last, it waits for software to clear the reset bit, and then it hands the port back to normal operation.

While the sequence runs, the block still decides how each incoming TLP aimed at the port is handled. A Type 0 configuration access to the port itself always completes locally. Any other TLP bound for the secondary side gets an unsupported-request disposition. Once the port is operational again, that second kind of TLP is forwarded. The upstream port, the other downstream ports and the sideband management interface have no connection to this block, so the reset does not touch them.

Top module: `secbus_reset_seq`

## Requirements
- R1: After reset the sequencer is in IDLE (state code 0) and the port is operational (`port_ready_o`=1). `hot_reset_o`, `flush_o` and `disp_valid_o` are all 0.
- R2: If the reset bit rises while the link is up, the state is HOTRST (code 1) from the next cycle and `hot_reset_o`=1. Both hold for as long as the reset bit stays set, even if the link drops in the meantime.
- R3: If the reset bit rises while the link is down, the next state is FLUSH (code 2) and `hot_reset_o` is never asserted.
- R4: `flush_o` is high for exactly one cycle: the first cycle in FLUSH. FLUSH is held for as long as `queue_busy_i`=1.
- R5: If the reset bit is still set when FLUSH ends, the state is WAIT (code 3). WAIT holds until the bit is clear, and the state is RUN (code 4) on the cycle after that.
- R6: If the reset bit is already clear when FLUSH ends (queue empty), the next state is RUN. `port_ready_o`=1 only in IDLE and RUN.
- R7: A TLP presented with `tlp_cfg0_i`=1 gets disposition code 1 (complete locally) in every state. The disposition appears with `disp_valid_o`=1 one cycle after the TLP is presented.
- R8: A TLP presented with `tlp_cfg0_i`=0 gets code 2 (unsupported request) when the port is not operational, and code 0 (forward) when it is. Code 3 is never produced.
- R9: A rising edge of the reset bit during HOTRST, FLUSH or WAIT does not restart the sequence and does not issue a second flush strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_bit_i | input | 1 | Secondary bus reset bit from the bridge control register |
| link_up_i | input | 1 | Port link is up |
| queue_busy_i | input | 1 | Queue still holds TLPs received from this port |
| tlp_valid_i | input | 1 | An incoming TLP is presented this cycle |
| tlp_cfg0_i | input | 1 | 1: Type 0 config access to the port; 0: TLP for the secondary side |
| hot_reset_o | output | 1 | Request hot-reset training sets |
| flush_o | output | 1 | One-cycle queue discard strobe |
| disp_valid_o | output | 1 | Disposition output is valid |
| disp_code_o | output | 2 | 0 forward, 1 complete locally, 2 unsupported request |
| port_ready_o | output | 1 | Port is in normal operation |
| state_o | output | 3 | Sequencer state code (IDLE 0, HOTRST 1, FLUSH 2, WAIT 3, RUN 4) |

## Verification
The hardest state to reach is WAIT. The hot-reset phase only ends when the reset bit clears, so a sequence that starts with the link up never finds the bit set after the flush. The stimulus therefore raises the bit with the link down and keeps it set through a queue drain of varying length, so that WAIT is entered and held. A separate directed case clears the bit and raises it again inside FLUSH to show that this second edge is ignored. TLPs of both kinds are presented on every cycle of every phase, so each disposition is checked against the state that was visible when the TLP was sampled.

// File: rtl/sbr_seq_pkg.sv
package sbr_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_HOTRST = 3'd1,
      ST_FLUSH  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_RUN    = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      DSP_FWD   = 2'd0,
      DSP_LOCAL = 2'd1,
      DSP_UR    = 2'd2
   } disp_e;

   function automatic logic st_operational(seq_state_e s);
      return (s == ST_IDLE) || (s == ST_RUN);
   endfunction
endpackage

// File: rtl/sbr_edge_detect.sv
module sbr_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/sbr_seq_fsm.sv
module sbr_seq_fsm
   import sbr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_i,
   input  logic       rise_i,
   input  logic       link_i,
   input  logic       busy_i,
   output seq_state_e state_o,
   output logic       hot_o,
   output logic       flush_o,
   output logic       ready_o
);
   seq_state_e st_q, st_d;
   logic       flush_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_RUN: if (rise_i) st_d = link_i ? ST_HOTRST : ST_FLUSH;
         ST_HOTRST:       if (!bit_i) st_d = ST_FLUSH;
         ST_FLUSH:        if (!busy_i) st_d = bit_i ? ST_WAIT : ST_RUN;
         ST_WAIT:         if (!bit_i) st_d = ST_RUN;
         default:         st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         flush_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         flush_q <= (st_d == ST_FLUSH) && (st_q != ST_FLUSH);
      end
   end

   assign state_o = st_q;
   assign hot_o   = (st_q == ST_HOTRST);
   assign flush_o = flush_q;
   assign ready_o = st_operational(st_q);

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o); // R4
   AST_FLUSH_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (st_q == ST_FLUSH)); // R4
   AST_HOT_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && rise_i) |=> (hot_o == $past(link_i))); // R2
   AST_NO_HOT_LINKDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && rise_i && !link_i) |=> (st_q == ST_FLUSH)); // R3
   AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_o && bit_i) |=> hot_o); // R2
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && bit_i) |=> (st_q == ST_WAIT)); // R5
   AST_FLUSH_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FLUSH && !busy_i && !bit_i) |=> (st_q == ST_RUN && ready_o)); // R6
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_o && rise_i) |=> !flush_o); // R9
endmodule

// File: rtl/sbr_tlp_disposer.sv
module sbr_tlp_disposer
   import sbr_seq_pkg::*;
#(
   parameter bit DISP_REG = 1'b1,
   parameter int CODE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic              valid_i,
   input  logic              cfg0_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int PAD_W = CODE_W - 2;
   disp_e code_d;

   always_comb begin
      if (cfg0_i)       code_d = DSP_LOCAL;
      else if (ready_i) code_d = DSP_FWD;
      else              code_d = DSP_UR;
   end

   generate
      if (DISP_REG) begin : g_reg
         logic        v_q;
         disp_e       c_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               c_q <= DSP_FWD;
            end else begin
               v_q <= valid_i;
               c_q <= code_d;
            end
         end
         assign valid_o = v_q;
         assign code_o  = {{PAD_W{1'b0}}, c_q};

         AST_UR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && !cfg0_i && !ready_i) |=> (valid_o && code_o == CODE_W'(DSP_UR))); // R8
         AST_CFG_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && cfg0_i) |=> (valid_o && code_o == CODE_W'(DSP_LOCAL))); // R7
      end else begin : g_comb
         assign valid_o = valid_i;
         assign code_o  = {{PAD_W{1'b0}}, code_d};

         AST_UR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && !cfg0_i && !ready_i) |-> (code_o == CODE_W'(DSP_UR))); // R8
         AST_CFG_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && cfg0_i) |-> (code_o == CODE_W'(DSP_LOCAL))); // R7
      end
   endgenerate

   AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (code_o != CODE_W'(3))); // R8
endmodule

// File: rtl/secbus_reset_seq.sv
module secbus_reset_seq
   import sbr_seq_pkg::*;
#(
   parameter bit DISP_REG = 1'b1,
   parameter int CODE_W   = 2,
   parameter int STATE_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reset_bit_i,
   input  logic               link_up_i,
   input  logic               queue_busy_i,
   input  logic               tlp_valid_i,
   input  logic               tlp_cfg0_i,
   output logic               hot_reset_o,
   output logic               flush_o,
   output logic               disp_valid_o,
   output logic [CODE_W-1:0]  disp_code_o,
   output logic               port_ready_o,
   output logic [STATE_W-1:0] state_o
);
   localparam int ENUM_W = $bits(seq_state_e);
   localparam int SPAD_W = STATE_W - ENUM_W;

   initial begin
      assert (CODE_W >= 2) else $error("CODE_W must be at least 2");
      assert (STATE_W >= ENUM_W) else $error("STATE_W too narrow for state codes");
   end

   logic       rise;
   seq_state_e st;
   logic       ready;

   sbr_edge_detect i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (reset_bit_i),
      .rise_o  (rise)
   );

   sbr_seq_fsm i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_i   (reset_bit_i),
      .rise_i  (rise),
      .link_i  (link_up_i),
      .busy_i  (queue_busy_i),
      .state_o (st),
      .hot_o   (hot_reset_o),
      .flush_o (flush_o),
      .ready_o (ready)
   );

   sbr_tlp_disposer #(.DISP_REG(DISP_REG), .CODE_W(CODE_W)) i_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready_i (ready),
      .valid_i (tlp_valid_i),
      .cfg0_i  (tlp_cfg0_i),
      .valid_o (disp_valid_o),
      .code_o  (disp_code_o)
   );

   assign port_ready_o = ready;
   assign state_o      = {{SPAD_W{1'b0}}, st};
endmodule

// File: tb/test_secbus_reset_seq.sv
module test_secbus_reset_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rbit = 1'b0, link = 1'b0, qbusy = 1'b0, tv = 1'b0, tcfg = 1'b0;
   logic       hot, flush, dv, pready;
   logic [1:0] dcode;
   logic [2:0] st;
   int checks = 0, errors = 0, tcnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   secbus_reset_seq i_secbus_reset_seq (
      .clk(clk), .rst_n(rst_n), .reset_bit_i(rbit), .link_up_i(link),
      .queue_busy_i(qbusy), .tlp_valid_i(tv), .tlp_cfg0_i(tcfg),
      .hot_reset_o(hot), .flush_o(flush), .disp_valid_o(dv),
      .disp_code_o(dcode), .port_ready_o(pready), .state_o(st)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input int s, input int h, input int f, input int r);
      chk({req, " state"}, st, s);
      chk({req, " hot"}, hot, h);
      chk({req, " flush"}, flush, f);
      chk({req, " ready"}, pready, r);
   endtask

   // present one TLP, advance one cycle, check its disposition (R7/R8)
   task automatic tick(input bit op_now);
      int exp;
      tcnt++;
      tv   = 1'b1;
      tcfg = tcnt[0];
      exp  = tcfg ? 1 : (op_now ? 0 : 2);
      @(negedge clk);
      chk(tcfg ? "R7 valid" : "R8 valid", dv, 1);
      chk(tcfg ? "R7 code" : "R8 code", dcode, exp);
   endtask

   task automatic scenario(input bit l, input int qb, input int h, input bit early);
      rbit = 1'b1; link = l; qbusy = (qb > 0);
      tick(1'b1);
      if (l) chk_state("R2 start", 1, 1, 0, 0);
      else   chk_state("R3 start", 2, 0, 1, 0);
      if (l) begin
         link = 1'b0;
         for (int i = 1; i < h; i++) begin
            tick(1'b0);
            chk_state("R2 hold", 1, 1, 0, 0);
         end
         rbit = 1'b0;
         tick(1'b0);
         chk_state("R4 enter", 2, 0, 1, 0);
      end else if (early) begin
         rbit = 1'b0;
      end
      for (int j = 0; j < qb; j++) begin
         tick(1'b0);
         chk_state("R4 drain", 2, 0, 0, 0);
      end
      qbusy = 1'b0;
      tick(1'b0);
      if (rbit) begin
         chk_state("R5 wait", 3, 0, 0, 0);
         for (int i = 1; i < h; i++) begin
            tick(1'b0);
            chk_state("R5 hold", 3, 0, 0, 0);
         end
         rbit = 1'b0;
         tick(1'b0);
      end
      chk_state("R6 run", 4, 0, 0, 1);
      tick(1'b1);
      chk_state("R6 stay", 4, 0, 0, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1", 0, 0, 0, 1);
      chk("R1 disp_valid", dv, 0);
      tick(1'b1);
      chk_state("R1 idle", 0, 0, 0, 1);

      for (int l = 0; l < 2; l++)
         for (int qb = 0; qb < 3; qb++)
            for (int h = 1; h < 4; h++)
               for (int e = 0; e < 2; e++)
                  if (!(l == 1 && e == 1)) scenario(l[0], qb, h, e[0]);

      // R9: second rising edge inside FLUSH is ignored
      rbit = 1'b1; link = 1'b0; qbusy = 1'b1;
      tick(1'b1);
      chk_state("R9 start", 2, 0, 1, 0);
      rbit = 1'b0;
      tick(1'b0);
      chk_state("R9 drain", 2, 0, 0, 0);
      rbit = 1'b1;
      tick(1'b0);
      chk_state("R9 reraise", 2, 0, 0, 0);
      tick(1'b0);
      chk_state("R9 no restrobe", 2, 0, 0, 0);
      qbusy = 1'b0;
      tick(1'b0);
      chk_state("R9 wait", 3, 0, 0, 0);
      rbit = 1'b0;
      tick(1'b0);
      chk_state("R9 run", 4, 0, 0, 1);

      tv = 1'b0;
      @(negedge clk);
      chk("R7 idle valid", dv, 0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule